// File: doc/BRIEF.md
# Direct-Mapped Cache With Victim Buffer

A read-only, line-granular cache made of a direct-mapped array and a small fully-associative side buffer. The processor presents a block address. Each access compares the address against the one direct-mapped line at its index and against every side-buffer entry in the same cycle. A hit in the direct-mapped array returns the line on the next cycle. A hit only in the side buffer costs one extra cycle and avoids the lower-level memory. A miss in both fetches the line through a single-request lower-level read port.

With `VICTIM_MODE = 1` the buffer keeps lines displaced from the direct-mapped array. A buffer hit exchanges the buffered line with the resident direct-mapped line. With `VICTIM_MODE = 0` the buffer acts as a miss cache. It keeps a copy of every fetched line, and a buffer hit copies the line into the direct-mapped array. In both modes, buffer entries are kept in recency order. A new entry or a hit entry moves to the most recently used position, and the least recently used entry is dropped when the buffer is full.

The processor request uses valid/ready. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response is a one-cycle `rsp_valid` pulse with no back-pressure, so the requester must always accept it. The lower-level request uses valid/ready as well: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. The lower-level response is a one-cycle `mem_rsp_valid` pulse that carries the line.

Top module: `victim_cache`

## Requirements
- R1: After reset every line and buffer entry is invalid, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The first access to any address goes to the lower level.
- R2: The direct-mapped index is the low log2(LINES) bits of the block address, and the rest of the address is the tag. Addresses that differ only in the tag compete for one line.
- R3: When the direct-mapped array hits, `rsp_valid` is 1 with the line in the cycle after acceptance, no lower-level request is made, and `req_ready` stays 1.
- R4: On a miss in both structures, `mem_req_valid` rises in the cycle after acceptance with `mem_req_addr` equal to the block address. It stays 1 with a stable address until `mem_req_ready`. The response carries `mem_rsp_data` and comes in the cycle after `mem_rsp_valid`.
- R5: `req_ready` is 0 from acceptance of any access that is not a direct-mapped hit until the cycle its response is presented, so at most one lower-level request is outstanding.
- R6: In victim mode a miss inserts the displaced direct-mapped line into the buffer at the most recently used position. The requested line is not inserted.
- R7: In victim mode a buffer hit returns the buffered line two cycles after acceptance with no lower-level request. That line moves into the direct-mapped array, and the displaced line takes the most recently used buffer slot.
- R8: A buffer hit promotes the hit entry to the most recently used position. An insertion into a full buffer discards the least recently used entry.
- R9: In miss-cache mode a fill writes the line into both the direct-mapped array and the buffer. A buffer hit copies the line into the direct-mapped array and keeps it in the buffer.
- R10: A displaced direct-mapped line that was invalid is not inserted into the buffer, and the buffer contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Requested block address |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | LINE_W | Returned line |
| mem_req_valid | output | 1 | Lower-level read request valid |
| mem_req_ready | input | 1 | Lower level accepts the request |
| mem_req_addr | output | ADDR_W | Block address to fetch |
| mem_rsp_valid | input | 1 | Lower-level data pulse |
| mem_rsp_data | input | LINE_W | Fetched line |

## Verification
A direct-mapped hit answers one cycle after acceptance, and a buffer hit answers two cycles after acceptance. A miss raises the lower-level request one cycle after acceptance and answers one cycle after the memory data pulse. The bench predicts which of these three outcomes each access produces from a behavioural model of the array and a recency-ordered queue. It then compares `rsp_valid`, `req_ready` and `mem_req_valid` at every falling edge up to the predicted response cycle, so a response that comes early or late is caught on the exact cycle. Memory handshake delays vary between accesses, which tests that the request is held and that the response follows the data pulse.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,   // waiting for a request
    ST_SWAP,   // buffer hit: exchange or copy line
    ST_MREQ,   // lower-level request presented
    ST_MWAIT   // waiting for lower-level data
  } vc_state_e;
endpackage

// File: rtl/vc_dm_array.sv
module vc_dm_array #(
  parameter int ADDR_W = 8,
  parameter int LINE_W = 16,
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ADDR_W  = 8,
  parameter int LINE_W  = 16,
  parameter int ENTRIES = 2,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic [LINE_W-1:0] hit_data,
  // place a new entry at slot 0 (most recent), closing the gap at upd_slot
  input  logic              upd_en,
  input  logic [SLOT_W-1:0] upd_slot,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [LINE_W-1:0] upd_data
);
  logic              v_q [ENTRIES];
  logic [ADDR_W-1:0] a_q [ENTRIES];
  logic [LINE_W-1:0] d_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  // one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = v_q[g] && (a_q[g] == probe_addr);
  end

  always_comb begin
    hit      = 1'b0;
    hit_slot = '0;
    hit_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && match[i]) begin
        hit      = 1'b1;
        hit_slot = SLOT_W'(i);
        hit_data = d_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        v_q[i] <= 1'b0;
        a_q[i] <= '0;
        d_q[i] <= '0;
      end
    end else if (upd_en) begin
      for (int i = ENTRIES - 1; i > 0; i--) begin
        if (i <= int'(upd_slot)) begin
          v_q[i] <= v_q[i-1];
          a_q[i] <= a_q[i-1];
          d_q[i] <= d_q[i-1];
        end
      end
      v_q[0] <= upd_valid;
      a_q[0] <= upd_addr;
      d_q[0] <= upd_data;
    end
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int ADDR_W      = 8,
  parameter int LINE_W      = 16,
  parameter int LINES       = 4,
  parameter int VB_ENTRIES  = 2,
  parameter bit VICTIM_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [LINE_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  import vc_pkg::*;

  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int SLOT_W = (VB_ENTRIES > 1) ? $clog2(VB_ENTRIES) : 1;
  localparam logic [SLOT_W-1:0] LRU_SLOT = SLOT_W'(VB_ENTRIES - 1);

  vc_state_e         state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic              rsp_valid_q;
  logic [LINE_W-1:0] rsp_data_q;

  logic [ADDR_W-1:0] probe_addr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              dm_valid, dm_hit;
  logic [TAG_W-1:0]  dm_tag;
  logic [LINE_W-1:0] dm_data;
  logic              vb_hit;
  logic [SLOT_W-1:0] vb_slot;
  logic [LINE_W-1:0] vb_data;
  logic              accept, fill, swap;
  logic              dm_wr_en;
  logic [LINE_W-1:0] dm_wr_data;
  logic              vb_upd_en, vb_upd_valid;
  logic [SLOT_W-1:0] vb_upd_slot;
  logic [ADDR_W-1:0] vb_upd_addr;
  logic [LINE_W-1:0] vb_upd_data;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign fill       = (state_q == ST_MWAIT) && mem_rsp_valid;
  assign swap       = (state_q == ST_SWAP);
  assign probe_addr = (state_q == ST_IDLE) ? req_addr : cur_addr_q;
  assign idx        = probe_addr[IDX_W-1:0];
  assign tag        = probe_addr[ADDR_W-1:IDX_W];
  assign dm_hit     = dm_valid && (dm_tag == tag);

  assign dm_wr_en   = fill || swap;
  assign dm_wr_data = fill ? mem_rsp_data : vb_data;

  vc_dm_array #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .LINES(LINES)) u_dm (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .rd_valid(dm_valid), .rd_tag(dm_tag), .rd_data(dm_data),
    .wr_en(dm_wr_en), .wr_idx(idx), .wr_tag(tag), .wr_data(dm_wr_data)
  );

  vc_victim_buf #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .ENTRIES(VB_ENTRIES)) u_vb (
    .clk(clk), .rst_n(rst_n), .probe_addr(probe_addr),
    .hit(vb_hit), .hit_slot(vb_slot), .hit_data(vb_data),
    .upd_en(vb_upd_en), .upd_slot(vb_upd_slot), .upd_valid(vb_upd_valid),
    .upd_addr(vb_upd_addr), .upd_data(vb_upd_data)
  );

  assign vb_upd_slot = swap ? vb_slot : LRU_SLOT;

  if (VICTIM_MODE) begin : g_victim
    // displaced direct-mapped line enters the buffer
    assign vb_upd_en    = swap || (fill && dm_valid);
    assign vb_upd_valid = dm_valid;
    assign vb_upd_addr  = {dm_tag, idx};
    assign vb_upd_data  = dm_data;
  end else begin : g_miss
    // requested line is kept in the buffer as well
    assign vb_upd_en    = swap || fill;
    assign vb_upd_valid = 1'b1;
    assign vb_upd_addr  = probe_addr;
    assign vb_upd_data  = fill ? mem_rsp_data : vb_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_addr_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cur_addr_q <= req_addr;
          if (dm_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= dm_data;
          end else if (vb_hit) begin
            state_q <= ST_SWAP;
          end else begin
            state_q <= ST_MREQ;
          end
        end
        ST_SWAP: begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= vb_data;
          state_q     <= ST_IDLE;
        end
        ST_MREQ: if (mem_req_ready) state_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= mem_rsp_data;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = cur_addr_q;
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int ADDR_W = 8,
  parameter int LINE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr
);
  assert_stall_during_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_hold_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_no_rsp_while_fetching_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid);

  assert_rsp_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready)));

  assert_ready_with_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> rsp_valid);
endmodule

bind victim_cache vc_checker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/tb_victim_cache.sv
module vc_harness #(
  parameter bit VICTIM = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   errs,
  output int   checks
);
  localparam int ADDR_W = 8;
  localparam int LINE_W = 16;
  localparam int LINES  = 4;
  localparam int NBUF   = 2;

  logic              req_valid, req_ready, rsp_valid;
  logic [ADDR_W-1:0] req_addr, mem_req_addr;
  logic [LINE_W-1:0] rsp_data, mem_rsp_data;
  logic              mem_req_valid, mem_req_ready, mem_rsp_valid;

  victim_cache #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .LINES(LINES),
                 .VB_ENTRIES(NBUF), .VICTIM_MODE(VICTIM)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // behavioural model: direct-mapped slots and a recency-ordered queue
  bit                m_v [LINES];
  logic [ADDR_W-1:0] m_a [LINES];
  logic [ADDR_W-1:0] m_q [$];

  function automatic logic [LINE_W-1:0] mem_fn(input logic [ADDR_W-1:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s mode=%0d actual=%h expected=%h", r, VICTIM, act, exp);
    end
  endtask

  // kind: 0 = direct-mapped hit, 1 = buffer hit, 2 = miss
  task automatic model_step(input logic [ADDR_W-1:0] a, output int kind);
    int i = int'(a % LINES);
    int k = -1;
    foreach (m_q[j]) if (k < 0 && m_q[j] == a) k = j;
    if (m_v[i] && m_a[i] == a) kind = 0;
    else if (k >= 0) begin
      kind = 1;
      m_q.delete(k);
      if (VICTIM) begin if (m_v[i]) m_q.push_front(m_a[i]); end
      else m_q.push_front(a);
      m_v[i] = 1; m_a[i] = a;
    end else begin
      kind = 2;
      if (VICTIM) begin if (m_v[i]) m_q.push_front(m_a[i]); end
      else m_q.push_front(a);
      if (m_q.size() > NBUF) void'(m_q.pop_back());
      m_v[i] = 1; m_a[i] = a;
    end
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input int wait_rdy,
                        input int lat, input string r);
    int kind;
    @(negedge clk);
    chk({r, " R5 ready before request"}, 32'(req_ready), 1);
    req_valid = 1; req_addr = a;
    model_step(a, kind);
    @(negedge clk);
    req_valid = 0;
    if (kind == 0) begin
      chk({r, " R3 hit rsp_valid"}, 32'(rsp_valid), 1);
      chk({r, " R3 hit data"}, 32'(rsp_data), 32'(mem_fn(a)));
      chk({r, " R3 no mem request"}, 32'(mem_req_valid), 0);
    end else if (kind == 1) begin
      chk({r, " R7 buffer hit wait"}, {30'd0, rsp_valid, mem_req_valid}, 0);
      chk({r, " R5 stalled"}, 32'(req_ready), 0);
      @(negedge clk);
      chk({r, " R7 buffer hit rsp_valid"}, 32'(rsp_valid), 1);
      chk({r, " R7 buffer hit data"}, 32'(rsp_data), 32'(mem_fn(a)));
    end else begin
      chk({r, " R4 mem request"}, 32'(mem_req_valid), 1);
      chk({r, " R4 mem addr"}, 32'(mem_req_addr), 32'(a));
      chk({r, " R5 stalled"}, {30'd0, req_ready, rsp_valid}, 0);
      for (int w = 0; w < wait_rdy; w++) begin
        @(negedge clk);
        chk({r, " R4 request held"}, {23'd0, mem_req_valid, mem_req_addr}, {23'd0, 1'b1, a});
      end
      mem_req_ready = 1;
      @(negedge clk);
      mem_req_ready = 0;
      chk({r, " R4 request dropped"}, 32'(mem_req_valid), 0);
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        chk({r, " R5 waiting for data"}, {30'd0, req_ready, rsp_valid}, 0);
      end
      mem_rsp_valid = 1; mem_rsp_data = mem_fn(a);
      @(negedge clk);
      mem_rsp_valid = 0;
      chk({r, " R4 fill rsp_valid"}, 32'(rsp_valid), 1);
      chk({r, " R4 fill data"}, 32'(rsp_data), 32'(mem_fn(a)));
      chk({r, " R5 ready again"}, 32'(req_ready), 1);
    end
  endtask

  initial begin
    done = 0; errs = 0; checks = 0;
    req_valid = 0; req_addr = '0; mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    for (int i = 0; i < LINES; i++) begin m_v[i] = 0; m_a[i] = '0; end
    wait (rst_n === 1'b1);
    @(negedge clk);
    chk("R1 reset ready", 32'(req_ready), 1);
    chk("R1 reset outputs idle", {30'd0, rsp_valid, mem_req_valid}, 0);
    if (VICTIM) begin
      access(8'h01, 2, 3, "R1 cold miss");
      access(8'h01, 0, 0, "R2 same address hit");
      access(8'h05, 0, 1, "R2 R6 conflict miss");
      access(8'h01, 0, 0, "R7 swap back");
      access(8'h05, 0, 0, "R7 swap again");
      access(8'h09, 1, 0, "R6 second victim");
      access(8'h0D, 0, 2, "R8 full buffer");
      access(8'h02, 0, 0, "R10 invalid victim");
      access(8'h05, 0, 0, "R10 R8 oldest still present");
      access(8'h01, 3, 1, "R8 dropped line refetched");
      access(8'h09, 0, 0, "R8 promotion order");
      access(8'h02, 0, 0, "R2 other index hit");
    end else begin
      access(8'h01, 1, 2, "R9 first fill");
      access(8'h01, 0, 0, "R3 hit");
      access(8'h05, 0, 1, "R9 second fill");
      access(8'h01, 0, 0, "R9 copy from buffer");
      access(8'h05, 0, 0, "R9 line kept in buffer");
      access(8'h09, 2, 0, "R8 miss-cache eviction");
      access(8'h01, 0, 1, "R8 least recent dropped");
    end
    done = 1;
  end
endmodule

module tb_victim_cache;
  localparam int CLK_PERIOD = 10;
  logic clk = 0;
  logic rst_n = 0;
  logic done_v, done_m;
  int   errs_v, errs_m, chk_v, chk_m;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vc_harness #(.VICTIM(1'b1)) u_victim (.clk(clk), .rst_n(rst_n), .done(done_v),
                                        .errs(errs_v), .checks(chk_v));
  vc_harness #(.VICTIM(1'b0)) u_miss (.clk(clk), .rst_n(rst_n), .done(done_m),
                                      .errs(errs_m), .checks(chk_m));

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
  end

  initial begin
    int errors, total;
    fork
      wait (done_v === 1'b1 && done_m === 1'b1);
      repeat (20000) @(posedge clk);
    join_any
    errors = errs_v + errs_m;
    total  = chk_v + chk_m;
    if (!(done_v === 1'b1 && done_m === 1'b1)) begin
      errors++; total++;
      $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    end
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule